// File: doc/BRIEF.md
# Configuration File Header Parser

This block walks a packed configuration file as it arrives one byte at a time. The file opens with a fixed 13-byte signature. After the signature comes a chain of tagged sections. Each section is a one-byte tag, then a big-endian length, then that many content bytes.

Sections tagged 'a' to 'd' carry descriptive text. The parser skips them without looking at their content. The section tagged 'e' holds the raw device bitstream. Its content bytes are passed straight through to a payload stream, and its length is presented for a downstream loader that works in 32-bit words.

The block is one-shot. After it reports success or failure, it stops taking input until the next reset.

Both streams use valid/ready handshakes:
- A byte moves on a clock edge only when valid and ready are both high.
- During the payload, the input's ready follows the payload output's ready. Back-pressure from the consumer therefore stalls the producer, and no byte is dropped or repeated.
- The payload path has no storage. `pay_valid` and `pay_data` follow the input combinationally while the payload is being forwarded.

Top module: `cfg_hdr_parser`

## Requirements
- R1: The first 13 accepted bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 in that order. A mismatch at any position sets `fail` and leaves `found` low.
- R2: A tag byte outside 0x61..0x65 (ASCII 'a'..'e') sets `fail`.
- R3: The length after tag 0x65 is 4 bytes, most significant first. The length after any other valid tag is 2 bytes, most significant first. The 4-byte value appears on `pay_len` once its last byte is accepted.
- R4: A 2-byte length greater than 255 sets `fail`. A value of exactly 255 is accepted. The 4-byte length has no such limit.
- R5: A section with tag 'a'..'d' is skipped by consuming exactly its length in content bytes. None of those bytes appears on the payload output.
- R6: The content bytes of the 'e' section, and only those, appear on `pay_data` in input order. `pay_words` equals `pay_len` divided by 4, rounded down.
- R7: `found` rises on the clock edge that accepts the last payload byte. For a zero-length 'e' section it rises on the edge that accepts the last length byte.
- R8: If a byte accepted with `in_last` high does not complete the 'e' section, `fail` is set and `found` stays low.
- R9: While payload is being forwarded and `pay_ready` is low, `in_ready` is low, so no payload byte is lost.
- R10: Once `found` or `fail` is set, it holds, and `in_ready` and `pay_valid` stay low until reset.
- R11: After reset, `in_ready` is high, `found` and `fail` are low, and `pay_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the file |
| in_ready | output | 1 | Parser can accept an input byte |
| pay_valid | output | 1 | Payload byte valid |
| pay_data | output | 8 | Payload byte |
| pay_ready | input | 1 | Consumer accepts the payload byte |
| pay_len | output | 32 | Payload length in bytes |
| pay_words | output | 30 | Payload length in 32-bit words |
| found | output | 1 | Payload section fully forwarded |
| fail | output | 1 | Format error or early end of file |

## Verification
Random files are generated with several skipped sections of random tag and size ahead of the payload. Some have junk after the payload, and some end exactly on the last payload byte. Input gaps and consumer stalls are random. Comparing the forwarded bytes against the payload shows that skipping is exact and that back-pressure neither loses nor duplicates bytes. Directed files then isolate single faults, one per run:
- a corrupted signature byte;
- tags just outside the valid range;
- a short length of 256 against 255;
- a zero-length payload;
- a truncated payload with a large 4-byte length, which shows the byte order of the length field.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int SIG_LEN = 13;

  typedef enum logic [2:0] {
    PS_SIG, PS_TAG, PS_LEN, PS_SKIP, PS_PAY, PS_DONE, PS_FAIL
  } pstate_e;

  function automatic logic [7:0] sig_byte(input int unsigned idx);
    case (idx)
      0, 10, 11: sig_byte = 8'h00;
      1:         sig_byte = 8'h09;
      2, 4, 6, 8: sig_byte = 8'h0F;
      3, 5, 7, 9: sig_byte = 8'hF0;
      default:   sig_byte = 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/cfg_hdr_sig.sv
module cfg_hdr_sig #(
  parameter int N = cfg_hdr_pkg::SIG_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] byte_in,
  output logic       mismatch,
  output logic       at_end
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (step && idx != LAST) idx <= idx + 1'b1;
  end

  assign mismatch = byte_in != cfg_hdr_pkg::sig_byte(32'(idx));
  assign at_end   = idx == LAST;

  // R1
  sig_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);
endmodule

// File: rtl/cfg_hdr_count.sv
module cfg_hdr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_one
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign is_one = cnt == W'(1);

  // R5
  count_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt != '0);
endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser #(
  parameter int          LEN_W     = 32,
  parameter int          SHORT_B   = 2,
  parameter int          SHORT_MAX = 255,
  parameter logic [7:0]  TAG_FIRST = 8'h61,
  parameter logic [7:0]  TAG_PAY   = 8'h65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             pay_valid,
  output logic [7:0]       pay_data,
  input  logic             pay_ready,
  output logic [LEN_W-1:0] pay_len,
  output logic [LEN_W-3:0] pay_words,
  output logic             found,
  output logic             fail
);
  import cfg_hdr_pkg::*;

  localparam int LONG_B = LEN_W / 8;
  localparam int LB_W   = $clog2(LONG_B + 1);

  pstate_e          st, nxt;
  logic [LEN_W-1:0] len_acc, new_len;
  logic [LB_W-1:0]  len_left;
  logic             is_pay;
  logic             accept;
  logic             sig_step, sig_bad, sig_end;
  logic             cnt_load, cnt_dec, cnt_one;

  cfg_hdr_sig #(.N(SIG_LEN)) u_sig (
    .clk(clk), .rst_n(rst_n), .step(sig_step), .byte_in(in_data),
    .mismatch(sig_bad), .at_end(sig_end)
  );

  cfg_hdr_count #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(new_len),
    .dec(cnt_dec), .is_one(cnt_one)
  );

  assign in_ready  = (st == PS_SIG) || (st == PS_TAG) || (st == PS_LEN) ||
                     (st == PS_SKIP) || (st == PS_PAY && pay_ready);
  assign accept    = in_valid && in_ready;
  assign pay_valid = (st == PS_PAY) && in_valid;
  assign pay_data  = in_data;
  assign new_len   = {len_acc[LEN_W-9:0], in_data};
  assign found     = st == PS_DONE;
  assign fail      = st == PS_FAIL;
  assign pay_words = pay_len[LEN_W-1:2];

  always_comb begin
    nxt      = st;
    sig_step = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (accept) begin
      case (st)
        PS_SIG: begin
          sig_step = 1'b1;
          if (sig_bad)      nxt = PS_FAIL;
          else if (sig_end) nxt = PS_TAG;
        end
        PS_TAG:
          nxt = (in_data >= TAG_FIRST && in_data <= TAG_PAY) ? PS_LEN : PS_FAIL;
        PS_LEN:
          if (len_left == LB_W'(1)) begin
            if (!is_pay && new_len > LEN_W'(SHORT_MAX)) nxt = PS_FAIL;
            else if (new_len == '0) nxt = is_pay ? PS_DONE : PS_TAG;
            else begin
              cnt_load = 1'b1;
              nxt      = is_pay ? PS_PAY : PS_SKIP;
            end
          end
        PS_SKIP, PS_PAY: begin
          cnt_dec = 1'b1;
          if (cnt_one) nxt = (st == PS_PAY) ? PS_DONE : PS_TAG;
        end
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PS_SIG;
      len_acc  <= '0;
      len_left <= '0;
      is_pay   <= 1'b0;
      pay_len  <= '0;
    end else begin
      if (accept && in_last && nxt != PS_DONE) st <= PS_FAIL;
      else                                      st <= nxt;
      if (accept && st == PS_TAG) begin
        is_pay   <= in_data == TAG_PAY;
        len_left <= (in_data == TAG_PAY) ? LB_W'(LONG_B) : LB_W'(SHORT_B);
        len_acc  <= '0;
      end
      if (accept && st == PS_LEN) begin
        len_acc  <= new_len;
        len_left <= len_left - 1'b1;
        if (is_pay && len_left == LB_W'(1)) pay_len <= new_len;
      end
    end
  end

  // R10
  found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> found);
  // R10
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);
  // R8
  flag_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && fail));
  // R9
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && in_ready) |-> pay_ready);
  // R7
  found_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> $past(accept));
endmodule

// File: tb/cfg_hdr_parser_tb.sv
`timescale 1ns/1ps
module cfg_hdr_parser_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, pay_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, pay_valid, found, fail;
  logic [7:0] pay_data;
  logic [31:0] pay_len;
  logic [29:0] pay_words;

  always #2.5 clk = ~clk;

  cfg_hdr_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .pay_valid(pay_valid),
    .pay_data(pay_data), .pay_ready(pay_ready), .pay_len(pay_len),
    .pay_words(pay_words), .found(found), .fail(fail)
  );

  int checks = 0, errors = 0;
  logic [7:0] stim[$];
  logic [7:0] exp_pay[$];
  logic [7:0] got[$];
  bit bp_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sigb(input int i);
    logic [7:0] t[13] = '{8'h00,8'h09,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h00,8'h00,8'h01};
    return t[i];
  endfunction

  task automatic new_file();
    stim.delete(); exp_pay.delete();
    for (int i = 0; i < 13; i++) stim.push_back(sigb(i));
  endtask

  task automatic add_sect(input logic [7:0] tag, input int unsigned len, input int fill);
    stim.push_back(tag);
    if (tag == 8'h65) begin
      stim.push_back(len[31:24]); stim.push_back(len[23:16]);
    end
    stim.push_back(len[15:8]); stim.push_back(len[7:0]);
    for (int i = 0; i < fill; i++) begin
      logic [7:0] b = 8'($urandom);
      stim.push_back(b);
      if (tag == 8'h65) exp_pay.push_back(b);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_last = 1'b0; pay_ready = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run();
    int i = 0;
    got.delete(); bp_bad = 1'b0;
    do_reset();
    while (i < stim.size() && !found && !fail) begin
      if ($urandom % 4 == 0) in_valid = 1'b0;
      else begin
        in_valid = 1'b1; in_data = stim[i]; in_last = (i == stim.size() - 1);
      end
      pay_ready = ($urandom % 3) != 0;
      #1;
      if (pay_valid && pay_ready) got.push_back(pay_data);
      if (pay_valid && !pay_ready && in_ready) bp_bad = 1'b1;
      if (in_valid && in_ready) i++;
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_ok(input string tag);
    chk(found === 1'b1, "R7", {tag, " found"}, found, 1);
    chk(fail === 1'b0, "R8", {tag, " fail"}, fail, 0);
    chk(pay_len == 32'(exp_pay.size()), "R3", {tag, " pay_len"}, pay_len, exp_pay.size());
    chk(pay_words == 30'(exp_pay.size() / 4), "R6", {tag, " pay_words"}, pay_words, exp_pay.size() / 4);
    chk(got == exp_pay, "R5", {tag, " payload bytes"}, got.size(), exp_pay.size());
    chk(!bp_bad, "R9", {tag, " ready under stall"}, bp_bad, 0);
  endtask

  task automatic expect_fail(input string req, input string tag);
    chk(fail === 1'b1, req, {tag, " fail"}, fail, 1);
    chk(found === 1'b0, req, {tag, " found"}, found, 0);
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R11 reset state
    chk(in_ready === 1'b1, "R11", "in_ready", in_ready, 1);
    chk(found === 1'b0 && fail === 1'b0, "R11", "flags", {found, fail}, 0);
    chk(pay_len == 0, "R11", "pay_len", pay_len, 0);

    // random files: R5 R6 R7 R9
    for (int k = 0; k < 10; k++) begin
      int n = $urandom % 4;
      int pl = $urandom % 38;
      new_file();
      for (int s = 0; s < n; s++) begin
        int ln = $urandom % 21;
        add_sect(8'h61 + 8'($urandom % 4), ln, ln);
      end
      add_sect(8'h65, pl, pl);
      if (k % 2 == 1) for (int j = 0; j < 3; j++) stim.push_back(8'h65);
      run();
      expect_ok($sformatf("random file %0d", k));
    end

    // R1 bad signature byte
    for (int k = 0; k < 3; k++) begin
      int p = $urandom % 13;
      new_file(); add_sect(8'h65, 4, 4);
      stim[p] = stim[p] ^ 8'h20;
      run(); expect_fail("R1", $sformatf("signature pos %0d", p));
    end

    // R2 tags just outside range
    new_file(); add_sect(8'h66, 1, 1); add_sect(8'h65, 4, 4);
    run(); expect_fail("R2", "tag 0x66");
    new_file(); add_sect(8'h60, 1, 1); add_sect(8'h65, 4, 4);
    run(); expect_fail("R2", "tag 0x60");

    // R4 short length limits
    new_file(); add_sect(8'h63, 256, 256); add_sect(8'h65, 4, 4);
    run(); expect_fail("R4", "short length 256");
    new_file(); add_sect(8'h62, 255, 255); add_sect(8'h65, 8, 8);
    run(); expect_ok("R4 short length 255");

    // R7 zero-length payload
    new_file(); add_sect(8'h61, 3, 3); add_sect(8'h65, 0, 0);
    run(); expect_ok("R7 zero payload");

    // R3 R8 truncated large payload
    new_file(); add_sect(8'h65, 32'h01000003, 5);
    run();
    expect_fail("R8", "truncated payload");
    chk(pay_len == 32'h01000003, "R3", "4-byte length order", pay_len, 32'h01000003);

    // R8 end inside a skipped section
    new_file(); add_sect(8'h64, 10, 4);
    run(); expect_fail("R8", "end inside skipped section");

    // R10 nothing taken after completion
    new_file(); add_sect(8'h65, 4, 4);
    run();
    in_valid = 1'b1; in_data = 8'h55; pay_ready = 1'b1;
    for (int j = 0; j < 4; j++) begin
      #1;
      chk(!in_ready && !pay_valid, "R10", "idle after found", {in_ready, pay_valid}, 0);
      @(posedge clk); @(negedge clk);
    end
    chk(found === 1'b1, "R10", "found held", found, 1);
    in_valid = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule